// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block holds the configuration and address registers of a physical memory protection unit for a 32-bit core. Software reaches it through a simple control-register port: an address, write data, a write enable and an operation code that selects a plain write, a bit-set, a bit-clear or a read only. Each configuration register packs four 8-bit entry configurations, and each entry has its own 32-bit address register.

Every configuration byte passes through its own legalizer before it is stored. The legalizer forces the reserved bits to zero. It discards a byte that would select the unsupported four-byte match mode, and it discards a byte that would grant write without read. A set lock bit freezes the entry. It also freezes the address register below the entry when that entry matches on a top-of-range basis.

The stored values are driven straight out of the block to a separate address-matching checker. The read port is registered.

Top module: `pmp_cfg_bank`

## Requirements
- R1: The configuration registers sit at addresses 0x3A0 and 0x3A1. Entry 4k+j occupies bits 8j+7:8j of register k. All configuration bytes are zero after reset.
- R2: Address register i sits at 0x3B0+i, holds all 32 written bits, and is zero after reset.
- R3: Bits 6:5 of every configuration byte always read zero, whatever was written.
- R4: A configuration byte whose result would have R (bit 0) = 0 and W (bit 1) = 1 is discarded, and that byte keeps its previous value.
- R5: A configuration byte whose result would select match mode 2 in bits 4:3 is discarded, and that byte keeps its previous value. The modes are 0 = off, 1 = top of range, 2 = four-byte, 3 = naturally aligned power of two.
- R6: Each of the four bytes of a configuration write is legalized on its own, so a legal byte is stored even when another byte of the same word is discarded.
- R7: When the lock bit (bit 7) of an entry is set, writes to that entry's configuration byte are ignored until reset.
- R8: When the lock bit of entry i is set, writes to address register i are ignored until reset.
- R9: When entry i+1 is locked with match mode 1 (top of range), writes to address register i are ignored.
- R10: csr_op selects the operation: 0 stores the write data, 1 sets the bits that are 1 in the write data, 2 clears the bits that are 1 in the write data, and 3 writes nothing. Set and clear act on the current register value, and the result is legalized as for a write.
- R11: csr_rdata shows, one clock after the request, the value the addressed register held before any write made in that same cycle. Unmapped addresses read zero.
- R12: pmp_cfg_o and pmp_addr_o show the stored values and change on the clock edge that stores a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data or bit mask |
| csr_we | input | 1 | Write request |
| csr_op | input | 2 | 0 write, 1 set, 2 clear, 3 read only |
| csr_rdata | output | 32 | Registered read data |
| pmp_cfg_o | output | 64 | All entry configuration bytes, entry i at bits 8i+7:8i |
| pmp_addr_o | output | 256 | All address registers, entry i at bits 32i+31:32i |

## Verification
Directed configuration words mix one legal byte with bytes that are legal, write-without-read, four-byte mode and reserved-bit-dirty. This tells per-byte legalization apart from whole-word discard. Set and clear operations are applied to words that were already legalized, so that combining with the old value before the legality check is exposed.

A locked top-of-range entry is placed above an unlocked one, which separates the entry's own address lock from the neighbour lock. A lock on the top entry checks the edge with no neighbour. A long pseudo-random mix of addresses, including unmapped ones, and all four operations is then compared every clock against a behavioural model. A mid-run reset shows that locks clear only through reset.

// File: rtl/pmp_cfg_bank_pkg.sv
package pmp_cfg_bank_pkg;

  localparam logic [1:0] OP_WRITE = 2'd0;
  localparam logic [1:0] OP_SET   = 2'd1;
  localparam logic [1:0] OP_CLEAR = 2'd2;
  localparam logic [1:0] OP_READ  = 2'd3;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_NA4   = 2'd2;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } entry_cfg_t;

  // Combine the current register value with the request according to op.
  function automatic logic [31:0] merge_op(input logic [1:0] op,
                                           input logic [31:0] cur,
                                           input logic [31:0] wd);
    logic [31:0] res;
    case (op)
      OP_WRITE: res = wd;
      OP_SET:   res = cur | wd;
      OP_CLEAR: res = cur & ~wd;
      default:  res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pmp_cfg_lane.sv
module pmp_cfg_lane
  import pmp_cfg_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic [7:0] cfg_q
);

  entry_cfg_t cand;
  entry_cfg_t cur;
  logic       reject;
  logic [7:0] legal_byte;

  assign cand = entry_cfg_t'(wbyte);
  assign cur  = entry_cfg_t'(cfg_q);

  always_comb begin
    reject = cur.lock
           || (cand.mode == MODE_NA4)
           || (!cand.r && cand.w);
    legal_byte = {cand.lock, 2'b00, cand.mode, cand.x, cand.w, cand.r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we && !reject) begin
      cfg_q <= legal_byte;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cfg_q == 8'h00));

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg_q[6:5] == 2'b00));

  assert_no_wo_R4: assert property (@(posedge clk) disable iff (rst)
    (we && !wbyte[0] && wbyte[1]) |=> (cfg_q == $past(cfg_q)));

  assert_no_na4_R5: assert property (@(posedge clk) disable iff (rst)
    (we && wbyte[4:3] == MODE_NA4) |=> (cfg_q == $past(cfg_q)));

  assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_q[7] |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/pmp_addr_reg.sv
module pmp_addr_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            locked,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (we && !locked) begin
      addr_q <= wdata;
    end
  end

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> (addr_q == '0));

  assert_locked_hold_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> (addr_q == $past(addr_q)));

  assert_write_lands_R12: assert property (@(posedge clk) disable iff (rst)
    (we && !locked) |=> (addr_q == $past(wdata)));

endmodule

// File: rtl/pmp_read_port.sv
module pmp_read_port #(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned NUM_CFG     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_CFG-1:0]          cfg_sel,
  input  logic [NUM_ENTRIES-1:0]      addr_sel,
  input  logic [NUM_CFG*XLEN-1:0]     cfg_flat,
  input  logic [NUM_ENTRIES*XLEN-1:0] addr_flat,
  output logic [XLEN-1:0]             rdata
);

  logic [XLEN-1:0] rd_next;
  logic            any_sel;

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < int'(NUM_CFG); k++) begin
      if (cfg_sel[k]) rd_next = rd_next | cfg_flat[k*XLEN +: XLEN];
    end
    for (int i = 0; i < int'(NUM_ENTRIES); i++) begin
      if (addr_sel[i]) rd_next = rd_next | addr_flat[i*XLEN +: XLEN];
    end
  end

  assign any_sel = (|cfg_sel) | (|addr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_next;
    end
  end

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !any_sel |=> (rdata == '0));

endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_cfg_bank_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned CSR_AW      = 12,
  parameter int unsigned CFG_BASE    = 12'h3A0,
  parameter int unsigned ADDR_BASE   = 12'h3B0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CSR_AW-1:0]           csr_addr,
  input  logic [XLEN-1:0]             csr_wdata,
  input  logic                        csr_we,
  input  logic [1:0]                  csr_op,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [NUM_ENTRIES*8-1:0]    pmp_cfg_o,
  output logic [NUM_ENTRIES*XLEN-1:0] pmp_addr_o
);

  localparam int unsigned PER_WORD = XLEN / 8;
  localparam int unsigned NUM_CFG  = NUM_ENTRIES / PER_WORD;

  logic                   wr_req;
  logic [NUM_CFG-1:0]     cfg_sel;
  logic [NUM_ENTRIES-1:0] addr_sel;
  logic [XLEN-1:0]        cfg_merged [NUM_CFG];
  logic [NUM_ENTRIES-1:0] ent_lock;
  logic [NUM_ENTRIES-1:0] ent_tor;
  logic [NUM_ENTRIES-1:0] addr_frozen;

  assign wr_req = csr_we && (csr_op != OP_READ);

  // Configuration words: decode, merge with the op, split into lanes.
  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg_word
    assign cfg_sel[k]    = (csr_addr == CSR_AW'(CFG_BASE + k));
    assign cfg_merged[k] = merge_op(csr_op, pmp_cfg_o[k*XLEN +: XLEN], csr_wdata);
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    localparam int unsigned WORD = i / PER_WORD;
    localparam int unsigned LANE = i % PER_WORD;

    logic [XLEN-1:0] addr_merged;

    pmp_cfg_lane u_lane (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_req && cfg_sel[WORD]),
      .wbyte (cfg_merged[WORD][8*LANE +: 8]),
      .cfg_q (pmp_cfg_o[8*i +: 8])
    );

    assign ent_lock[i] = pmp_cfg_o[8*i+7];
    assign ent_tor[i]  = (pmp_cfg_o[8*i+3 +: 2] == MODE_TOR);

    // An address register is frozen by its own lock or by a locked
    // top-of-range entry directly above it.
    if (i < NUM_ENTRIES - 1) begin : g_nbr
      assign addr_frozen[i] = ent_lock[i] | (ent_lock[i+1] & ent_tor[i+1]);

      assert_tor_guard_R9: assert property (@(posedge clk) disable iff (rst)
        (ent_lock[i+1] && ent_tor[i+1] && wr_req && addr_sel[i])
          |=> (pmp_addr_o[i*XLEN +: XLEN] == $past(pmp_addr_o[i*XLEN +: XLEN])));
    end else begin : g_top
      assign addr_frozen[i] = ent_lock[i];
    end

    assign addr_sel[i]  = (csr_addr == CSR_AW'(ADDR_BASE + i));
    assign addr_merged  = merge_op(csr_op, pmp_addr_o[i*XLEN +: XLEN], csr_wdata);

    pmp_addr_reg #(.XLEN(XLEN)) u_addr (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_req && addr_sel[i]),
      .locked (addr_frozen[i]),
      .wdata  (addr_merged),
      .addr_q (pmp_addr_o[i*XLEN +: XLEN])
    );
  end

  pmp_read_port #(
    .XLEN        (XLEN),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_CFG     (NUM_CFG)
  ) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cfg_sel   (cfg_sel),
    .addr_sel  (addr_sel),
    .cfg_flat  (pmp_cfg_o),
    .addr_flat (pmp_addr_o),
    .rdata     (csr_rdata)
  );

  assert_single_decode_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_sel, addr_sel}));

  assert_read_only_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_op == OP_READ) |=> ($stable(pmp_cfg_o) && $stable(pmp_addr_o)));

endmodule

// File: tb/pmp_cfg_bank_tb.sv
module pmp_cfg_bank_tb;

  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   csr_addr = '0;
  logic [31:0]   csr_wdata = '0;
  logic          csr_we = 1'b0;
  logic [1:0]    csr_op = 2'd3;
  logic [31:0]   csr_rdata;
  logic [N*8-1:0]  pmp_cfg_o;
  logic [N*32-1:0] pmp_addr_o;

  int vectors = 0;
  int miscompares = 0;

  // Reference state
  logic [7:0]  m_cfg  [N];
  logic [31:0] m_addr [N];
  logic [31:0] exp_rd;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  pmp_cfg_bank u_dut (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_op(csr_op), .csr_rdata(csr_rdata),
    .pmp_cfg_o(pmp_cfg_o), .pmp_addr_o(pmp_addr_o)
  );

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h3A0 || a == 12'h3A1) begin
      int k = int'(a - 12'h3A0);
      return {m_cfg[4*k+3], m_cfg[4*k+2], m_cfg[4*k+1], m_cfg[4*k]};
    end
    if (a >= 12'h3B0 && a < 12'h3B0 + N) return m_addr[int'(a - 12'h3B0)];
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_combine(input logic [1:0] op,
                                            input logic [31:0] cur,
                                            input logic [31:0] d);
    if (op == 2'd0) return d;
    if (op == 2'd1) return cur | d;
    if (op == 2'd2) return cur & ~d;
    return cur;
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [1:0] op,
                         input logic [31:0] d);
    logic [7:0] old_cfg [N];
    for (int e = 0; e < N; e++) old_cfg[e] = m_cfg[e];
    if (a == 12'h3A0 || a == 12'h3A1) begin
      int k = int'(a - 12'h3A0);
      logic [31:0] nw = m_combine(op, m_read(a), d);
      for (int j = 0; j < 4; j++) begin
        logic [7:0] b = nw[8*j +: 8];
        int e = 4*k + j;
        bit bad = old_cfg[e][7] || (b[4:3] == 2'd2) || (!b[0] && b[1]);
        if (!bad) m_cfg[e] = b & 8'h9F;
      end
    end else if (a >= 12'h3B0 && a < 12'h3B0 + N) begin
      int i = int'(a - 12'h3B0);
      bit frozen = old_cfg[i][7];
      if (i < N-1 && old_cfg[i+1][7] && old_cfg[i+1][4:3] == 2'd1) frozen = 1;
      if (!frozen) m_addr[i] = m_combine(op, m_addr[i], d);
    end
  endtask

  task automatic check_all(input string tag);
    bit bad = 0;
    vectors++;
    if (csr_rdata !== exp_rd) begin
      $display("FAIL %s rdata actual=%h expected=%h", tag, csr_rdata, exp_rd);
      bad = 1;
    end
    for (int e = 0; e < N; e++) begin
      if (pmp_cfg_o[8*e +: 8] !== m_cfg[e]) begin
        $display("FAIL %s cfg[%0d] actual=%h expected=%h", tag, e,
                 pmp_cfg_o[8*e +: 8], m_cfg[e]);
        bad = 1;
      end
      if (pmp_addr_o[32*e +: 32] !== m_addr[e]) begin
        $display("FAIL %s addr[%0d] actual=%h expected=%h", tag, e,
                 pmp_addr_o[32*e +: 32], m_addr[e]);
        bad = 1;
      end
    end
    if (bad) miscompares++;
  endtask

  // Called at a falling edge; applies one request for one clock.
  task automatic step(input logic [11:0] a, input logic [31:0] d,
                      input logic we, input logic [1:0] op, input string tag);
    csr_addr = a; csr_wdata = d; csr_we = we; csr_op = op;
    exp_rd = m_read(a);
    if (we && op != 2'd3) m_write(a, op, d);
    @(posedge clk);
    @(negedge clk);
    csr_we = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1; csr_we = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    exp_rd = '0;
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog expired actual=running expected=done");
    miscompares++;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("R1 R2 reset state");

    // Mixed word: TOR legal, NA4, write-only, reserved-dirty NAPOT.
    step(12'h3A0, 32'h7B02_120F, 1, 2'd0, "R6 per-byte legalize");
    step(12'h3A0, 32'h0, 0, 2'd3, "R3 R4 R5 readback");
    step(12'h3A1, 32'h0000_0002, 1, 2'd0, "R4 write-only discarded");
    step(12'h3A1, 32'h0000_0010, 1, 2'd0, "R5 four-byte mode discarded");
    step(12'h3A1, 32'h6060_6061, 1, 2'd0, "R3 reserved bits dropped");
    step(12'h3A1, 32'h0, 0, 2'd3, "R1 cfg1 readback");

    // Operations
    step(12'h3A0, 32'h0000_0400, 1, 2'd1, "R10 set op");
    step(12'h3A0, 32'h0000_0001, 1, 2'd2, "R10 clear gives write-only, discarded");
    step(12'h3A0, 32'h0000_0004, 1, 2'd2, "R10 clear op");
    step(12'h3A0, 32'hFFFF_FFFF, 1, 2'd3, "R10 read-only op");

    // Address registers
    for (int i = 0; i < N; i++)
      step(12'h3B0 + 12'(i), 32'hA500_0000 + 32'(i * 32'h1111), 1, 2'd0, "R2 addr write");
    step(12'h3B3, 32'h0000_00FF, 1, 2'd1, "R10 addr set");
    step(12'h3B3, 32'h0000_000F, 1, 2'd2, "R10 addr clear");
    step(12'h3B3, 32'h0, 0, 2'd0, "R11 read old value");
    step(12'h3B9, 32'h1234_5678, 1, 2'd0, "R11 unmapped read zero");
    step(12'h3A2, 32'h1234_5678, 1, 2'd0, "R11 unmapped cfg slot");
    step(12'h3B5, 32'h0000_0777, 1, 2'd0, "R12 write then read same cycle");

    // Locks: entry 5 locked TOR, entry 7 locked NAPOT
    step(12'h3A1, 32'h9800_8800, 1, 2'd0, "R7 set locks");
    step(12'h3A1, 32'h0000_0000, 1, 2'd0, "R7 locked bytes hold");
    step(12'h3A1, 32'h0000_0300, 1, 2'd1, "R7 set on locked byte");
    step(12'h3B5, 32'hDEAD_BEEF, 1, 2'd0, "R8 locked entry addr");
    step(12'h3B4, 32'hDEAD_BEEF, 1, 2'd0, "R9 addr below locked TOR");
    step(12'h3B6, 32'hDEAD_BEEF, 1, 2'd0, "R9 addr below locked NAPOT");
    step(12'h3B7, 32'hDEAD_BEEF, 1, 2'd0, "R8 top entry locked");
    step(12'h3B3, 32'hCAFE_0003, 1, 2'd0, "R9 unrelated addr writes");
    step(12'h3A1, 32'h0000_0003, 1, 2'd0, "R6 unlocked byte beside locked");

    // Pseudo-random mix
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'd0: a = 12'h3A0 + 12'(lfsr[3:2]);
        2'd1, 2'd2: a = 12'h3B0 + 12'(lfsr[6:4]);
        default: a = lfsr[19:8];
      endcase
      d = {lfsr[15:0], lfsr[31:16]};
      if (lfsr[9:7] != 3'd0) d = d & 32'h7F7F_7F7F;
      step(a, d, lfsr[11] | lfsr[12], lfsr[14:13], "R6 random mix");
      if (n == 300) do_reset("R7 reset clears locks");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule